// File: doc/BRIEF.md
# Shared Timebase with Per-Context Compare Timers

This block holds one free-running counter that all processor contexts share, plus a 64-bit compare register and a timer interrupt line for each context. The counter width is fixed at build time to 32 bits plus a multiple of four, up to 64. Software reads the count as two 32-bit words. A stop flag in the configuration word freezes the count, and software can preload either half while the count is frozen.

Each context programs its own compare value through a local window. It writes the upper word first and the lower word second, and the lower-word write arms the timer. A context can also select another context and reach that context's compare value through a second window. All accesses use a simple single-cycle register bus. The bus carries the index of the issuing context, and read data returns one cycle after the request.

Top module: `shared_timebase`

## Requirements
- R1: After a synchronous reset the count is zero and the stop flag (configuration word bit 0) is 1. Every compare value and every context's selector are zero, all timer lines are low, and read-valid is low.
- R2: While the stop flag is 1 and no preload is written, the count holds its value. Writing 0 to the stop flag resumes counting from the held value. The write edge that clears the flag does not itself count, and the write edge that sets the flag still counts once.
- R3: While running, the count rises by one on every clock and wraps to zero after 2^W-1, where W = 32 + 4*CNT_EXT. The carry from the lower word into the upper word lands on the same clock, so both halves always come from one value.
- R4: Configuration word bits 11:8 read CNT_EXT, cannot be written, and all other configuration bits except bit 0 read zero. Counter bits at or above W read zero, and preload data for those bits is dropped.
- R5: Writing the lower compare word (word 4 locally, word 8 through the window) arms that context. The timer line rises on the second clock edge after that write if the count is then at or above the 64-bit compare value. Once high, it stays high until the next compare write to that context.
- R6: Writing either compare word of a context drops its timer line on that write's clock edge. Writing the upper word (word 5 locally, word 9 through the window) disarms the context until the next lower-word write.
- R7: Word 6 holds a per-context selector. Words 8 and 9 issued by a context read and write the compare value of the context named by that context's selector.
- R8: A selector that names no existing context, or a bus context index that names no existing context, makes window (or local) writes do nothing and reads return zero.
- R9: Read data appears with read-valid high exactly one cycle after a read request, and read-valid is low otherwise. The word map is: 0 configuration, 1 count low, 2 count high, 4/5 local compare low/high, 6 selector, 8/9 window compare low/high. Every other word reads zero.
- R10: A compare write reaches only its target context. The compare values and timer lines of the other contexts are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ctx | input | CTX_W | Index of the context issuing the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High one cycle after a read strobe |
| tmr_irq | output | NUM_CTX | Per-context timer interrupt |

## Verification
The bench builds the block with three contexts and CNT_EXT of 4, which gives a 48-bit count. With this width, masking of the upper counter bits is visible in the upper read word, and a preload near the top of the range makes wrap-around reachable in a few cycles. Three contexts on a two-bit index leave selector value 3 without a target, so the rejected-window path and the rejected bus index can both be driven. Timer edges are checked on exact cycles against a frozen and then released count.

// File: rtl/st_pkg.sv
package st_pkg;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] W_CFG     = 4'd0;
  localparam logic [ADDR_W-1:0] W_CNT_LO  = 4'd1;
  localparam logic [ADDR_W-1:0] W_CNT_HI  = 4'd2;
  localparam logic [ADDR_W-1:0] W_LCMP_LO = 4'd4;
  localparam logic [ADDR_W-1:0] W_LCMP_HI = 4'd5;
  localparam logic [ADDR_W-1:0] W_OSEL    = 4'd6;
  localparam logic [ADDR_W-1:0] W_OCMP_LO = 4'd8;
  localparam logic [ADDR_W-1:0] W_OCMP_HI = 4'd9;

  function automatic int ctx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/st_counter.sv
module st_counter #(
  parameter int CNT_EXT = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        stop,
  input  logic        ld_lo,
  input  logic        ld_hi,
  input  logic [31:0] wdata,
  output logic [63:0] cnt
);

  localparam int          W        = 32 + 4 * CNT_EXT;
  localparam logic [63:0] CNT_MASK = {64{1'b1}} >> (64 - W);

  logic [63:0] cnt_q;
  logic [63:0] cnt_nx;
  logic [63:0] ld_val;

  // one wide register: both halves change on the same edge
  always_comb begin
    ld_val = {ld_hi ? wdata : cnt_q[63:32], ld_lo ? wdata : cnt_q[31:0]};
    if (ld_lo || ld_hi)
      cnt_nx = ld_val & CNT_MASK;
    else if (!stop)
      cnt_nx = (cnt_q + 64'd1) & CNT_MASK;
    else
      cnt_nx = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nx;
  end

  assign cnt = cnt_q;

  // R2
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (stop && !ld_lo && !ld_hi) |=> $stable(cnt_q));

  // R3
  step_when_running_chk: assert property (@(posedge clk) disable iff (rst)
    (!stop && !ld_lo && !ld_hi) |=> (cnt_q == (($past(cnt_q) + 64'd1) & CNT_MASK)));

endmodule

// File: rtl/st_ctx_timer.sv
module st_ctx_timer (
  input  logic        clk,
  input  logic        rst,
  input  logic [63:0] cnt,
  input  logic        we_lo,
  input  logic        we_hi,
  input  logic [31:0] wdata,
  output logic [63:0] cmp,
  output logic        irq
);

  logic [63:0] cmp_q;
  logic        armed_q;
  logic        irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q   <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (we_hi) cmp_q[63:32] <= wdata;
      if (we_lo) cmp_q[31:0]  <= wdata;

      if (we_lo)      armed_q <= 1'b1;
      else if (we_hi) armed_q <= 1'b0;

      if (we_lo || we_hi)
        irq_q <= 1'b0;
      else if (armed_q && (cnt >= cmp_q))
        irq_q <= 1'b1;
    end
  end

  assign cmp = cmp_q;
  assign irq = irq_q;

  // R6
  drop_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we_lo || we_hi) |=> !irq_q);

  // R5
  rise_needs_reach_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> ($past(cnt) >= $past(cmp_q)));

  // R5
  sticky_until_write_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !we_lo && !we_hi) |=> irq_q);

endmodule

// File: rtl/st_regif.sv
module st_regif
  import st_pkg::*;
#(
  parameter  int NUM_CTX = 4,
  parameter  int CNT_EXT = 8,
  localparam int CTX_W   = ctx_width(NUM_CTX)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CTX_W-1:0]        bus_ctx,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [CTX_W-1:0]        wdata_low,
  input  logic [63:0]             cnt,
  input  logic [NUM_CTX-1:0][63:0] cmp_all,
  output logic                    stop,
  output logic                    cnt_ld_lo,
  output logic                    cnt_ld_hi,
  output logic [NUM_CTX-1:0]      cmp_we_lo,
  output logic [NUM_CTX-1:0]      cmp_we_hi,
  output logic [31:0]             rdata,
  output logic                    rvalid
);

  logic                          stop_q;
  logic [NUM_CTX-1:0][CTX_W-1:0] osel_q;
  logic [CTX_W-1:0]              osel_cur;
  logic                          ctx_ok;
  logic                          win_ok;
  logic [31:0]                   rd_nx;
  logic [31:0]                   rdata_q;
  logic                          rvalid_q;

  always_comb begin
    ctx_ok   = int'(bus_ctx) < NUM_CTX;
    osel_cur = ctx_ok ? osel_q[bus_ctx] : '0;
    win_ok   = ctx_ok && (int'(osel_cur) < NUM_CTX);
  end

  assign cnt_ld_lo = bus_wr && (bus_addr == W_CNT_LO);
  assign cnt_ld_hi = bus_wr && (bus_addr == W_CNT_HI);

  // compare write strobes, one per context
  always_comb begin
    for (int i = 0; i < NUM_CTX; i++) begin
      cmp_we_lo[i] = bus_wr &&
        ((ctx_ok && (bus_addr == W_LCMP_LO) && (bus_ctx == CTX_W'(i))) ||
         (win_ok && (bus_addr == W_OCMP_LO) && (osel_cur == CTX_W'(i))));
      cmp_we_hi[i] = bus_wr &&
        ((ctx_ok && (bus_addr == W_LCMP_HI) && (bus_ctx == CTX_W'(i))) ||
         (win_ok && (bus_addr == W_OCMP_HI) && (osel_cur == CTX_W'(i))));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= 1'b1;
      osel_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == W_CFG) stop_q <= wdata_low[0];
      if (ctx_ok && (bus_addr == W_OSEL)) osel_q[bus_ctx] <= wdata_low;
    end
  end

  assign stop = stop_q;

  always_comb begin
    rd_nx = '0;
    case (bus_addr)
      W_CFG:     rd_nx = {20'd0, 4'(CNT_EXT), 7'd0, stop_q};
      W_CNT_LO:  rd_nx = cnt[31:0];
      W_CNT_HI:  rd_nx = cnt[63:32];
      W_LCMP_LO: if (ctx_ok) rd_nx = cmp_all[bus_ctx][31:0];
      W_LCMP_HI: if (ctx_ok) rd_nx = cmp_all[bus_ctx][63:32];
      W_OSEL:    if (ctx_ok) rd_nx = 32'(osel_cur);
      W_OCMP_LO: if (win_ok) rd_nx = cmp_all[osel_cur][31:0];
      W_OCMP_HI: if (win_ok) rd_nx = cmp_all[osel_cur][63:32];
      default:   rd_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rd_nx;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  // R9
  read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> rvalid_q);

  // R9
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !rvalid_q);

  // R10
  single_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmp_we_lo) && $onehot0(cmp_we_hi));

  // R2
  stop_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == W_CFG)) |=> (stop_q == $past(wdata_low[0])));

endmodule

// File: rtl/shared_timebase.sv
module shared_timebase
  import st_pkg::*;
#(
  parameter  int NUM_CTX = 4,
  parameter  int CNT_EXT = 8,
  localparam int CTX_W   = ctx_width(NUM_CTX)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CTX_W-1:0]   bus_ctx,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  output logic [NUM_CTX-1:0] tmr_irq
);

  logic                     stop;
  logic                     cnt_ld_lo;
  logic                     cnt_ld_hi;
  logic [63:0]              cnt;
  logic [NUM_CTX-1:0]       cmp_we_lo;
  logic [NUM_CTX-1:0]       cmp_we_hi;
  logic [NUM_CTX-1:0][63:0] cmp_all;

  st_regif #(.NUM_CTX(NUM_CTX), .CNT_EXT(CNT_EXT)) u_regif (
    .clk       (clk),
    .rst       (rst),
    .bus_ctx   (bus_ctx),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .wdata_low (bus_wdata[CTX_W-1:0]),
    .cnt       (cnt),
    .cmp_all   (cmp_all),
    .stop      (stop),
    .cnt_ld_lo (cnt_ld_lo),
    .cnt_ld_hi (cnt_ld_hi),
    .cmp_we_lo (cmp_we_lo),
    .cmp_we_hi (cmp_we_hi),
    .rdata     (bus_rdata),
    .rvalid    (bus_rvalid)
  );

  st_counter #(.CNT_EXT(CNT_EXT)) u_counter (
    .clk   (clk),
    .rst   (rst),
    .stop  (stop),
    .ld_lo (cnt_ld_lo),
    .ld_hi (cnt_ld_hi),
    .wdata (bus_wdata),
    .cnt   (cnt)
  );

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    st_ctx_timer u_timer (
      .clk   (clk),
      .rst   (rst),
      .cnt   (cnt),
      .we_lo (cmp_we_lo[g]),
      .we_hi (cmp_we_hi[g]),
      .wdata (bus_wdata),
      .cmp   (cmp_all[g]),
      .irq   (tmr_irq[g])
    );
  end

endmodule

// File: tb/shared_timebase_tb.sv
module shared_timebase_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCTX = 3;
  localparam int EXT  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_ctx = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [NCTX-1:0] tmr_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_timebase #(.NUM_CTX(NCTX), .CNT_EXT(EXT)) u_dut (
    .clk(clk), .rst(rst), .bus_ctx(bus_ctx), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .tmr_irq(tmr_irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input int c, input logic [3:0] a, input logic [31:0] d);
    bus_ctx = c[1:0]; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int c, input logic [3:0] a, output logic [31:0] d);
    bus_ctx = c[1:0]; bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    chk("R9 rvalid on read", 64'(bus_rvalid), 64'd1);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq low", 64'(tmr_irq), 64'd0);
    chk("R1 rvalid low", 64'(bus_rvalid), 64'd0);
    rd(0, 4'd0, d); chk("R1 cfg stop=1 code=4", 64'(d), 64'h401);
    rd(0, 4'd1, d); chk("R1 count low", 64'(d), 64'd0);
    rd(0, 4'd2, d); chk("R1 count high", 64'(d), 64'd0);
    rd(1, 4'd4, d); chk("R1 compare zero", 64'(d), 64'd0);
    rd(2, 4'd6, d); chk("R1 selector zero", 64'(d), 64'd0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    rd(0, 4'd3, d); chk("R9 unmapped word", 64'(d), 64'd0);
    @(negedge clk); chk("R9 rvalid drops", 64'(bus_rvalid), 64'd0);
    rd(0, 4'd15, d); chk("R9 unmapped top word", 64'(d), 64'd0);
  endtask

  task automatic t_width();
    logic [31:0] d;
    wr(0, 4'd0, 32'hFFFF_FFFF);
    rd(0, 4'd0, d); chk("R4 cfg field read-only", 64'(d), 64'h401);
    wr(0, 4'd2, 32'hFFFF_FFFF);
    rd(0, 4'd2, d); chk("R4 upper bits masked", 64'(d), 64'h0000_FFFF);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    wr(0, 4'd1, 32'hFFFF_FFFE);
    wr(0, 4'd0, 32'd0);
    repeat (2) @(negedge clk);
    wr(0, 4'd0, 32'd1);
    rd(0, 4'd2, d); chk("R3 wrap high", 64'(d), 64'd0);
    rd(0, 4'd1, d); chk("R3 wrap low", 64'(d), 64'd1);
    wr(0, 4'd2, 32'h1234);
    wr(0, 4'd1, 32'hFFFF_FFFF);
    wr(0, 4'd0, 32'd0);
    wr(0, 4'd0, 32'd1);
    rd(0, 4'd2, d); chk("R3 carry high", 64'(d), 64'h1235);
    rd(0, 4'd1, d); chk("R3 carry low", 64'(d), 64'd0);
  endtask

  task automatic t_stop();
    logic [31:0] d0;
    logic [31:0] d1;
    rd(0, 4'd1, d0);
    repeat (5) @(negedge clk);
    rd(0, 4'd1, d1); chk("R2 frozen", 64'(d1), 64'(d0));
    wr(0, 4'd0, 32'd0);
    repeat (9) @(negedge clk);
    wr(0, 4'd0, 32'd1);
    rd(0, 4'd1, d1); chk("R2 resume from held", 64'(d1), 64'(d0) + 64'd10);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(0, 4'd2, 32'd0);
    wr(0, 4'd1, 32'd100);
    wr(1, 4'd5, 32'd0);
    wr(1, 4'd4, 32'd101);
    @(negedge clk); chk("R5 below compare", 64'(tmr_irq[1]), 64'd0);
    wr(0, 4'd0, 32'd0);
    chk("R5 start edge", 64'(tmr_irq[1]), 64'd0);
    @(negedge clk); chk("R5 one edge later", 64'(tmr_irq[1]), 64'd0);
    @(negedge clk); chk("R5 reached", 64'(tmr_irq[1]), 64'd1);
    chk("R10 other lines low", 64'({tmr_irq[2], tmr_irq[0]}), 64'd0);
    wr(0, 4'd0, 32'd1);
    chk("R5 sticky", 64'(tmr_irq[1]), 64'd1);
    wr(1, 4'd5, 32'd0);
    chk("R6 high write drops", 64'(tmr_irq[1]), 64'd0);
    @(negedge clk); chk("R6 disarmed", 64'(tmr_irq[1]), 64'd0);
    wr(1, 4'd4, 32'd0);
    chk("R6 low write edge", 64'(tmr_irq[1]), 64'd0);
    @(negedge clk); chk("R5 rearmed fires", 64'(tmr_irq[1]), 64'd1);
    wr(1, 4'd4, 32'hFFFF_FFFF);
    chk("R6 low write drops", 64'(tmr_irq[1]), 64'd0);
    @(negedge clk); chk("R5 above count stays low", 64'(tmr_irq[1]), 64'd0);
    rd(0, 4'd4, d); chk("R10 ctx0 compare untouched", 64'(d), 64'd0);
    rd(1, 4'd4, d); chk("R10 ctx1 compare", 64'(d), 64'hFFFF_FFFF);
  endtask

  task automatic t_window();
    logic [31:0] d;
    wr(2, 4'd6, 32'd0);
    wr(2, 4'd9, 32'd7);
    wr(2, 4'd8, 32'h55);
    rd(0, 4'd4, d); chk("R7 window low lands", 64'(d), 64'h55);
    rd(0, 4'd5, d); chk("R7 window high lands", 64'(d), 64'd7);
    rd(2, 4'd4, d); chk("R7 own compare untouched", 64'(d), 64'd0);
    wr(2, 4'd6, 32'd1);
    rd(2, 4'd6, d); chk("R7 selector readback", 64'(d), 64'd1);
    rd(0, 4'd6, d); chk("R7 selector per context", 64'(d), 64'd0);
    rd(2, 4'd8, d); chk("R7 window read", 64'(d), 64'hFFFF_FFFF);
  endtask

  task automatic t_badsel();
    logic [31:0] d;
    wr(2, 4'd6, 32'd3);
    wr(2, 4'd8, 32'h77);
    rd(2, 4'd8, d); chk("R8 bad selector reads zero", 64'(d), 64'd0);
    rd(0, 4'd4, d); chk("R8 ctx0 unchanged", 64'(d), 64'h55);
    rd(1, 4'd4, d); chk("R8 ctx1 unchanged", 64'(d), 64'hFFFF_FFFF);
    rd(2, 4'd4, d); chk("R8 ctx2 unchanged", 64'(d), 64'd0);
    wr(3, 4'd4, 32'h99);
    rd(3, 4'd4, d); chk("R8 bad bus context reads zero", 64'(d), 64'd0);
    rd(0, 4'd4, d); chk("R8 bad bus context write dropped", 64'(d), 64'h55);
    rd(2, 4'd4, d); chk("R8 ctx2 still zero", 64'(d), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_map();
    t_width();
    t_wrap();
    t_stop();
    t_irq();
    t_window();
    t_badsel();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule